// File: doc/BRIEF.md
# Receive Start and Reset Controller

This block is the control and status front end of a frame receiver. Software writes one control byte that holds three bits. Two of them are level controls: one holds the receive logic in reset and the other holds the receive FIFO in reset, and each works on its own. The third bit is a start request. The block turns it into a single-cycle start pulse for the receive state machine, but only when the bit changes from 0 to 1. To start another reception, software must clear the bit and then set it again.

The block keeps a busy flag. The start pulse sets it. The end of the frame or the logic reset clears it. Clearing the start bit while a frame is in progress has no effect on busy, so the only way to abort a frame is the logic reset. The block also keeps two CRC status channels, one for the 32-bit CRC and one for the 8-bit CRC. When the receiver reports a good CRC during a reception, the channel raises its flag and captures the live byte count of that moment. The channel then holds that value until the next start or a logic reset. The CRC computation itself happens outside this block.

Top module: `rx_ctl_top`

## Requirements
- R1: After reset every output is 0, including the readback, the flags and the latched counts.
- R2: Bit 7 of a control write sets `rx_logic_rst` to that bit value, visible in the cycle after the write. It has no effect on `rx_fifo_rst`.
- R3: Bit 6 of a control write sets `rx_fifo_rst` to that bit value, visible in the cycle after the write. It has no effect on `rx_logic_rst`, on busy or on the CRC status.
- R4: `rx_start_pulse` is high for exactly one cycle, the cycle after a write, when that write sets bit 0 while the stored bit 0 was 0 and the written bit 7 is 0. A write that keeps bit 0 at 1 gives no pulse.
- R5: `rx_busy` goes high in the cycle after the start pulse. It goes low in the cycle after `frame_end` is seen. If the start pulse and `frame_end` arrive in the same cycle, the start pulse wins.
- R6: Clearing bit 0 while busy does not clear `rx_busy` and does not touch the CRC status.
- R7: While `rx_logic_rst` is high, `rx_busy`, both CRC flags and both latched counts go to 0 at the next edge. A start written together with bit 7 set gives no pulse.
- R8: The first good-CRC strobe of a channel seen while busy sets that channel's flag and latches `byte_cnt` into its count, both visible in the next cycle. Later strobes change nothing, and strobes seen while not busy are ignored.
- R9: A start pulse clears both CRC flags and both counts at the next edge.
- R10: `ctl_rd_data` returns bit 7 as the logic reset, bit 6 as the FIFO reset and bit 0 as the start bit. All other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr_en | input | 1 | Control byte write strobe |
| ctl_wr_data | input | 8 | Control byte written |
| ctl_rd_data | output | 8 | Control byte readback |
| frame_end | input | 1 | Receiver reports end of frame |
| crc32_ok | input | 1 | 32-bit CRC checked good |
| crc8_ok | input | 1 | 8-bit CRC checked good |
| byte_cnt | input | CNT_W | Live receive byte count |
| rx_logic_rst | output | 1 | Receive logic reset |
| rx_fifo_rst | output | 1 | Receive FIFO reset |
| rx_start_pulse | output | 1 | One-cycle start to the receive state machine |
| rx_busy | output | 1 | Reception in progress |
| crc32_good | output | 1 | 32-bit CRC good flag |
| crc32_cnt | output | CNT_W | Byte count latched on 32-bit CRC good |
| crc8_good | output | 1 | 8-bit CRC good flag |
| crc8_cnt | output | CNT_W | Byte count latched on 8-bit CRC good |

## Verification
The bench walks through all 64 transitions between pairs of 3-bit control values. This catches a design that pulses on the level of the start bit instead of its rising edge, which would restart on every rewrite, and a design that lets a start through while the logic reset is written. It also catches a design that couples the two reset lines. Frame scenarios then clear the start bit in the middle of a frame, which catches a design that aborts on that clear. They send repeated CRC strobes with a changing byte count, which catches a design that overwrites the first latched count, and they send strobes while idle, which catches a design that latches outside a frame. A start pulse and `frame_end` are also placed in the same cycle, which catches a design that gives the wrong priority and loses the new frame.

// File: rtl/rx_ctl_pkg.sv
package rx_ctl_pkg;
    localparam int CTL_W     = 8;
    localparam int BIT_LRST  = 7;
    localparam int BIT_FRST  = 6;
    localparam int BIT_START = 0;
    localparam int N_CRC     = 2;

    typedef struct packed {
        logic lrst;
        logic frst;
        logic start;
    } ctl_t;
endpackage

// File: rtl/rx_ctl_reg.sv
module rx_ctl_reg
    import rx_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    output ctl_t             ctl,
    output logic             start_pulse
);
    typedef struct packed {
        ctl_t ctl;
        logic pulse;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.pulse = 1'b0;
        if (wr_en) begin
            s_d.ctl.lrst  = wr_data[BIT_LRST];
            s_d.ctl.frst  = wr_data[BIT_FRST];
            s_d.ctl.start = wr_data[BIT_START];
            // rising edge of start only, and never under a written logic reset
            s_d.pulse     = wr_data[BIT_START] & ~s_q.ctl.start & ~wr_data[BIT_LRST];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctl         = s_q.ctl;
    assign start_pulse = s_q.pulse;
endmodule

// File: rtl/rx_busy_trk.sv
module rx_busy_trk (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic set,
    input  logic done,
    output logic busy
);
    logic busy_d, busy_q;

    always_comb begin
        busy_d = busy_q;
        if (clr)       busy_d = 1'b0;
        else if (set)  busy_d = 1'b1;
        else if (done) busy_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= busy_d;
    end

    assign busy = busy_q;
endmodule

// File: rtl/rx_crc_latch.sv
module rx_crc_latch #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             arm,
    input  logic             ok,
    input  logic [CNT_W-1:0] cnt,
    output logic             good,
    output logic [CNT_W-1:0] cnt_held
);
    typedef struct packed {
        logic             good;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d = '0;
        end else if (arm && ok && !s_q.good) begin
            s_d.good = 1'b1;
            s_d.cnt  = cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign good     = s_q.good;
    assign cnt_held = s_q.cnt;
endmodule

// File: rtl/rx_ctl_top.sv
module rx_ctl_top
    import rx_ctl_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr_en,
    input  logic [7:0]       ctl_wr_data,
    output logic [7:0]       ctl_rd_data,
    input  logic             frame_end,
    input  logic             crc32_ok,
    input  logic             crc8_ok,
    input  logic [CNT_W-1:0] byte_cnt,
    output logic             rx_logic_rst,
    output logic             rx_fifo_rst,
    output logic             rx_start_pulse,
    output logic             rx_busy,
    output logic             crc32_good,
    output logic [CNT_W-1:0] crc32_cnt,
    output logic             crc8_good,
    output logic [CNT_W-1:0] crc8_cnt
);
    ctl_t             ctl;
    logic             pulse;
    logic             busy;
    logic [N_CRC-1:0] ok_vec;
    logic [N_CRC-1:0] good_vec;
    logic [CNT_W-1:0] cnt_arr [N_CRC];

    rx_ctl_reg u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (ctl_wr_en),
        .wr_data     (ctl_wr_data),
        .ctl         (ctl),
        .start_pulse (pulse)
    );

    rx_busy_trk u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctl.lrst),
        .set   (pulse),
        .done  (frame_end),
        .busy  (busy)
    );

    assign ok_vec = {crc8_ok, crc32_ok};

    for (genvar g = 0; g < N_CRC; g++) begin : g_crc
        rx_crc_latch #(.CNT_W(CNT_W)) u_lat (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (ctl.lrst | pulse),
            .arm      (busy),
            .ok       (ok_vec[g]),
            .cnt      (byte_cnt),
            .good     (good_vec[g]),
            .cnt_held (cnt_arr[g])
        );
    end

    always_comb begin
        ctl_rd_data            = '0;
        ctl_rd_data[BIT_LRST]  = ctl.lrst;
        ctl_rd_data[BIT_FRST]  = ctl.frst;
        ctl_rd_data[BIT_START] = ctl.start;
    end

    assign rx_logic_rst   = ctl.lrst;
    assign rx_fifo_rst    = ctl.frst;
    assign rx_start_pulse = pulse;
    assign rx_busy        = busy;
    assign crc32_good     = good_vec[0];
    assign crc32_cnt      = cnt_arr[0];
    assign crc8_good      = good_vec[1];
    assign crc8_cnt       = cnt_arr[1];
endmodule

// File: rtl/rx_ctl_chk.sv
module rx_ctl_chk #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_logic_rst,
    input logic             rx_start_pulse,
    input logic             rx_busy,
    input logic             crc32_good,
    input logic             crc8_good,
    input logic [CNT_W-1:0] crc32_cnt,
    input logic [CNT_W-1:0] crc8_cnt
);
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_start_pulse |=> !rx_start_pulse);

    a_r5_busy_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_start_pulse && !rx_logic_rst) |=> rx_busy);

    a_r7_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rx_logic_rst |=> (!rx_busy && !crc32_good && !crc8_good));

    a_r7_no_start_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        rx_start_pulse |-> !rx_logic_rst);

    a_r8_crc32_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc32_good) |-> $past(rx_busy));

    a_r8_crc32_cnt_held: assert property (@(posedge clk) disable iff (!rst_n)
        (crc32_good && !rx_logic_rst && !rx_start_pulse) |=> $stable(crc32_cnt));

    a_r8_crc8_cnt_held: assert property (@(posedge clk) disable iff (!rst_n)
        (crc8_good && !rx_logic_rst && !rx_start_pulse) |=> $stable(crc8_cnt));

    a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rx_start_pulse |=> (!crc32_good && !crc8_good));
endmodule

bind rx_ctl_top rx_ctl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rx_logic_rst   (rx_logic_rst),
    .rx_start_pulse (rx_start_pulse),
    .rx_busy        (rx_busy),
    .crc32_good     (crc32_good),
    .crc8_good      (crc8_good),
    .crc32_cnt      (crc32_cnt),
    .crc8_cnt       (crc8_cnt)
);

// File: tb/rx_ctl_top_tb.sv
module rx_ctl_top_tb;
    localparam int CNT_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ctl_wr_en = 1'b0;
    logic [7:0]       ctl_wr_data = '0;
    logic [7:0]       ctl_rd_data;
    logic             frame_end = 1'b0;
    logic             crc32_ok = 1'b0;
    logic             crc8_ok = 1'b0;
    logic [CNT_W-1:0] byte_cnt = '0;
    logic             rx_logic_rst, rx_fifo_rst, rx_start_pulse, rx_busy;
    logic             crc32_good, crc8_good;
    logic [CNT_W-1:0] crc32_cnt, crc8_cnt;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    rx_ctl_top #(.CNT_W(CNT_W)) u_dut (.*);

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // drive on falling edge, step one full cycle, land on next falling edge
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        ctl_wr_en = 1'b0;
        frame_end = 1'b0;
        crc32_ok  = 1'b0;
        crc8_ok   = 1'b0;
    endtask

    task automatic wr(input logic [2:0] c);
        ctl_wr_en   = 1'b1;
        ctl_wr_data = {c[2], c[1], 5'b0, c[0]};
        cyc();
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 ctl", {24'b0, ctl_rd_data}, 0);
        chk("R1 outs", {rx_logic_rst, rx_fifo_rst, rx_start_pulse, rx_busy, crc32_good, crc8_good}, 0);
        chk("R1 cnts", {crc32_cnt, crc8_cnt}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // exhaustive transitions between control codes: R2 R3 R4 R10
        for (int p = 0; p < 8; p++) begin
            for (int n = 0; n < 8; n++) begin
                logic [2:0] pc, nc;
                pc = 3'(p);
                nc = 3'(n);
                wr(pc);
                cyc();
                wr(nc);
                chk("R2 logic rst", rx_logic_rst, nc[2]);
                chk("R3 fifo rst", rx_fifo_rst, nc[1]);
                chk("R4 pulse", rx_start_pulse, nc[0] & ~pc[0] & ~nc[2]);
                chk("R10 readback", ctl_rd_data, {nc[2], nc[1], 5'b0, nc[0]});
                cyc();
                chk("R4 pulse one cycle", rx_start_pulse, 0);
                wr(3'b100);
                wr(3'b000);
                cyc();
            end
        end

        // R5 start, busy, frame end
        wr(3'b001);
        chk("R5 busy not yet", rx_busy, 0);
        cyc();
        chk("R5 busy set", rx_busy, 1);
        // R6 clearing start does not abort
        wr(3'b000);
        cyc();
        chk("R6 busy kept", rx_busy, 1);
        // R8 latch first strobe, count sweep
        for (int k = 1; k <= 20; k++) begin
            byte_cnt = 12'(k * 37);
            if (k == 5)  crc32_ok = 1'b1;
            if (k == 9)  crc8_ok  = 1'b1;
            if (k == 12) begin crc32_ok = 1'b1; crc8_ok = 1'b1; end
            cyc();
        end
        chk("R8 crc32 flag", crc32_good, 1);
        chk("R8 crc32 cnt", crc32_cnt, 5 * 37);
        chk("R8 crc8 flag", crc8_good, 1);
        chk("R8 crc8 cnt", crc8_cnt, 9 * 37);
        // R3 fifo reset does not disturb
        wr(3'b010);
        cyc();
        chk("R3 busy kept", rx_busy, 1);
        chk("R3 crc kept", crc32_cnt, 5 * 37);
        wr(3'b000);
        frame_end = 1'b1;
        cyc();
        chk("R5 busy cleared", rx_busy, 0);
        chk("R8 flag kept after end", crc8_good, 1);
        // idle strobes ignored
        byte_cnt = 12'hABC;
        crc32_ok = 1'b1;
        crc8_ok  = 1'b1;
        cyc();
        chk("R8 idle ignored", crc32_cnt, 5 * 37);
        chk("R8 idle ignored 8", crc8_cnt, 9 * 37);

        // R9 next start clears crc
        wr(3'b001);
        cyc();
        chk("R9 crc32 cleared", crc32_good, 0);
        chk("R9 cnt cleared", crc32_cnt, 0);
        chk("R9 crc8 cleared", crc8_good, 0);
        byte_cnt = 12'h123;
        crc8_ok  = 1'b1;
        cyc();
        chk("R8 new latch", crc8_cnt, 12'h123);
        // R7 logic reset aborts
        wr(3'b100);
        cyc();
        chk("R7 busy cleared", rx_busy, 0);
        chk("R7 crc cleared", {crc8_good, crc8_cnt}, 0);
        wr(3'b101);
        chk("R7 no start in reset", rx_start_pulse, 0);
        wr(3'b000);

        // R5 start and frame_end same cycle: start wins
        wr(3'b001);
        frame_end = 1'b1;
        cyc();
        chk("R5 start beats end", rx_busy, 1);
        frame_end = 1'b1;
        cyc();
        chk("R5 end clears", rx_busy, 0);
        // rewrite 1 without clearing: no restart
        wr(3'b001);
        chk("R4 no rearm", rx_start_pulse, 0);
        cyc();
        chk("R4 stays idle", rx_busy, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule